// File: doc/BRIEF.md
# Block Storage Key Protection Unit

This unit checks every storage reference against a per-block protection key before the access is let through. The 17-bit byte address space is divided into 64 blocks of 2048 bytes, and each block has a 3-bit key register. Privileged software loads the keys through a dedicated write port. Blocks that share a key value make up one segment, so at most eight segments can exist.

Two requesters are checked in parallel. The processor port carries the program number from the running program's status word. The channel port carries the program number bound to the I/O channel that is doing the transfer. For each request the unit takes the upper six address bits as the block index and reads that block's key. It compares the key with the requester's program number, looking for exact equality. One cycle later it raises either an access enable toward storage or a violation pulse.

A merged error-interrupt output combines the two violation pulses. It also reports the offending address and which port caused it. The storage array and the interrupt controller sit outside this block.

Top module: `blkkey_guard`

## Requirements
- R1: After reset every key register holds 0, and all grant, violation and error outputs are 0.
- R2: A key write with `kw_en` high stores `kw_key` into the register selected by `kw_blk`. That register is the one a request reaches when address bits [16:11] equal `kw_blk`.
- R3: A processor request (`cpu_req` high) in cycle N gives `cpu_grant` = 1 in cycle N+1 if the key of block `cpu_addr[16:11]` equals `cpu_pnum`. Otherwise it gives `cpu_viol` = 1 in N+1.
- R4: A channel request (`chn_req` high) is checked the same way against `chn_pnum`, using `chn_addr[16:11]`. Its result appears on `chn_grant` or `chn_viol` in N+1, whatever the processor port is doing.
- R5: Per port, grant and violation are never high in the same cycle.
- R6: A violation is a single-cycle pulse tied to one request. With no request in cycle N, both grant and violation of that port are 0 in N+1.
- R7: `err_irq` is 1 exactly in the cycles where either violation output is 1. `err_src` is 0 when the processor violated and 1 when only the channel did. `err_addr` is the offending request's address, and the processor's address wins when both violate. With no violation, `err_src` and `err_addr` are 0.
- R8: `err_dual` is 1 exactly when both ports violate in the same cycle.
- R9: A check made in the same cycle as a key write to the same block uses the old key. The new key takes effect for requests in the following cycle.
- R10: Block boundaries sit at 2048-byte steps. Addresses 0x007FF and 0x00800 use different keys, and 0x1FFFF uses key register 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kw_en | input | 1 | Key write enable |
| kw_blk | input | 6 | Block index of the key to load |
| kw_key | input | 3 | Key value to load |
| cpu_req | input | 1 | Processor access request |
| cpu_addr | input | 17 | Processor byte address |
| cpu_pnum | input | 3 | Program number from the status word |
| chn_req | input | 1 | Channel transfer request |
| chn_addr | input | 17 | Channel transfer byte address |
| chn_pnum | input | 3 | Program number bound to the channel |
| cpu_grant | output | 1 | Processor access enabled to storage |
| cpu_viol | output | 1 | Processor protection violation pulse |
| chn_grant | output | 1 | Channel transfer enabled to storage |
| chn_viol | output | 1 | Channel protection violation pulse |
| err_irq | output | 1 | Error interrupt pulse |
| err_addr | output | 17 | Address of the reported violation |
| err_src | output | 1 | Reporting port: 0 processor, 1 channel |
| err_dual | output | 1 | Both ports violated this cycle |

## Verification
The bench hits a key write and a check on the same block in one cycle. A design that forwards the new key would grant or reject a request one cycle early. It probes the addresses on each side of a 2048-byte boundary and the topmost address. A wrong slice of the address would read a neighbouring key there. It also forces both ports to violate together. A design with a wrong priority would report the channel's address, and one with the wrong dual flag would hide the second error. Random traffic draws keys and program numbers from a narrow range, so grants and violations both happen often and their interleaving gets exercised.

// File: rtl/blkkey_pkg.sv
package blkkey_pkg;
    localparam int ADDR_W = 17;
    localparam int BLK_W  = 6;
    localparam int KEY_W  = 3;
    localparam int NPORT  = 2;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_CHN = 1'b1
    } src_e;
endpackage

// File: rtl/blkkey_keyfile.sv
module blkkey_keyfile #(
    parameter int BLK_W = 6,
    parameter int KEY_W = 3,
    parameter int NRD   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BLK_W-1:0]           wr_blk,
    input  logic [KEY_W-1:0]           wr_key,
    input  logic [NRD-1:0][BLK_W-1:0]  rd_blk,
    output logic [NRD-1:0][KEY_W-1:0]  rd_key
);
    localparam int NUM_BLK = 1 << BLK_W;

    typedef struct packed {
        logic [NUM_BLK-1:0][KEY_W-1:0] keys;
    } kf_state_t;

    kf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.keys[wr_blk] = wr_key;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read ports see the registered keys: a write lands one cycle later.
    generate
        for (genvar i = 0; i < NRD; i++) begin : g_rd
            assign rd_key[i] = st_q.keys[rd_blk[i]];
        end
    endgenerate

    // Loaded key becomes visible on the next cycle (R2)
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.keys[$past(wr_blk)] == $past(wr_key));
endmodule

// File: rtl/blkkey_lane.sv
module blkkey_lane #(
    parameter int ADDR_W = 17,
    parameter int KEY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  pnum,
    input  logic [KEY_W-1:0]  key,
    output logic              grant,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_addr
);
    typedef struct packed {
        logic              grant;
        logic              viol;
        logic [ADDR_W-1:0] vaddr;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic        match;

    always_comb begin
        match    = (key == pnum);
        st_d     = '0;
        if (req) begin
            st_d.grant = match;
            st_d.viol  = !match;
            if (!match) begin
                st_d.vaddr = addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = st_q.grant;
    assign viol      = st_q.viol;
    assign viol_addr = st_q.vaddr;

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && viol));

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !grant && !viol);

    assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req && (key != pnum) |=> viol && viol_addr == $past(addr));
endmodule

// File: rtl/blkkey_report.sv
module blkkey_report #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_viol,
    input  logic [ADDR_W-1:0] cpu_vaddr,
    input  logic              chn_viol,
    input  logic [ADDR_W-1:0] chn_vaddr,
    output logic              irq,
    output logic [ADDR_W-1:0] irq_addr,
    output logic              irq_src,
    output logic              irq_dual
);
    import blkkey_pkg::*;

    src_e src;

    always_comb begin
        irq      = cpu_viol || chn_viol;
        irq_dual = cpu_viol && chn_viol;
        src      = SRC_CPU;
        irq_addr = '0;
        if (cpu_viol) begin
            irq_addr = cpu_vaddr;
        end else if (chn_viol) begin
            src      = SRC_CHN;
            irq_addr = chn_vaddr;
        end
        irq_src = src;
    end

    // Processor wins the report when both ports violate (R7)
    assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq && irq_src |-> !cpu_viol && chn_viol);

    assert_dual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dual |-> irq && !irq_src);
endmodule

// File: rtl/blkkey_guard.sv
module blkkey_guard
    import blkkey_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_BLK_W  = BLK_W,
    parameter int P_KEY_W  = KEY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kw_en,
    input  logic [P_BLK_W-1:0]  kw_blk,
    input  logic [P_KEY_W-1:0]  kw_key,
    input  logic                cpu_req,
    input  logic [P_ADDR_W-1:0] cpu_addr,
    input  logic [P_KEY_W-1:0]  cpu_pnum,
    input  logic                chn_req,
    input  logic [P_ADDR_W-1:0] chn_addr,
    input  logic [P_KEY_W-1:0]  chn_pnum,
    output logic                cpu_grant,
    output logic                cpu_viol,
    output logic                chn_grant,
    output logic                chn_viol,
    output logic                err_irq,
    output logic [P_ADDR_W-1:0] err_addr,
    output logic                err_src,
    output logic                err_dual
);
    localparam int LANES = NPORT;

    logic [LANES-1:0]                req_v;
    logic [LANES-1:0][P_ADDR_W-1:0]  addr_v;
    logic [LANES-1:0][P_KEY_W-1:0]   pnum_v;
    logic [LANES-1:0][P_BLK_W-1:0]   blk_v;
    logic [LANES-1:0][P_KEY_W-1:0]   key_v;
    logic [LANES-1:0]                grant_v;
    logic [LANES-1:0]                viol_v;
    logic [LANES-1:0][P_ADDR_W-1:0]  vaddr_v;

    // Lane 0 is the processor, lane 1 the channel.
    assign req_v  = {chn_req,  cpu_req};
    assign addr_v = {chn_addr, cpu_addr};
    assign pnum_v = {chn_pnum, cpu_pnum};

    blkkey_keyfile #(
        .BLK_W (P_BLK_W),
        .KEY_W (P_KEY_W),
        .NRD   (LANES)
    ) u_keyfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (kw_en),
        .wr_blk (kw_blk),
        .wr_key (kw_key),
        .rd_blk (blk_v),
        .rd_key (key_v)
    );

    generate
        for (genvar p = 0; p < LANES; p++) begin : g_lane
            assign blk_v[p] = addr_v[p][P_ADDR_W-1 -: P_BLK_W];

            blkkey_lane #(
                .ADDR_W (P_ADDR_W),
                .KEY_W  (P_KEY_W)
            ) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .req       (req_v[p]),
                .addr      (addr_v[p]),
                .pnum      (pnum_v[p]),
                .key       (key_v[p]),
                .grant     (grant_v[p]),
                .viol      (viol_v[p]),
                .viol_addr (vaddr_v[p])
            );
        end
    endgenerate

    assign cpu_grant = grant_v[0];
    assign cpu_viol  = viol_v[0];
    assign chn_grant = grant_v[1];
    assign chn_viol  = viol_v[1];

    blkkey_report #(
        .ADDR_W (P_ADDR_W)
    ) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_viol  (viol_v[0]),
        .cpu_vaddr (vaddr_v[0]),
        .chn_viol  (viol_v[1]),
        .chn_vaddr (vaddr_v[1]),
        .irq       (err_irq),
        .irq_addr  (err_addr),
        .irq_src   (err_src),
        .irq_dual  (err_dual)
    );

    // Ports are checked independently: a channel request always yields a result (R4)
    assert_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chn_req |=> chn_grant || chn_viol);

    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(cpu_req) || $past(chn_req));
endmodule

// File: tb/blkkey_guard_bench.sv
module blkkey_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kw_en = 1'b0;
    logic [5:0]  kw_blk = '0;
    logic [2:0]  kw_key = '0;
    logic        cpu_req = 1'b0;
    logic [16:0] cpu_addr = '0;
    logic [2:0]  cpu_pnum = '0;
    logic        chn_req = 1'b0;
    logic [16:0] chn_addr = '0;
    logic [2:0]  chn_pnum = '0;
    logic        cpu_grant, cpu_viol, chn_grant, chn_viol;
    logic        err_irq, err_src, err_dual;
    logic [16:0] err_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] mdl [64];

    always #4 clk = ~clk;

    blkkey_guard u_blkkey_guard (
        .clk(clk), .rst_n(rst_n),
        .kw_en(kw_en), .kw_blk(kw_blk), .kw_key(kw_key),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_pnum(cpu_pnum),
        .chn_req(chn_req), .chn_addr(chn_addr), .chn_pnum(chn_pnum),
        .cpu_grant(cpu_grant), .cpu_viol(cpu_viol),
        .chn_grant(chn_grant), .chn_viol(chn_viol),
        .err_irq(err_irq), .err_addr(err_addr),
        .err_src(err_src), .err_dual(err_dual)
    );

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic key_ok(input logic [16:0] a, input logic [2:0] p);
        return mdl[a[16:11]] == p;
    endfunction

    // One cycle: drive at a falling edge, check results one full cycle later.
    task automatic step(input logic we, input logic [5:0] wb, input logic [2:0] wk,
                        input logic cr, input logic [16:0] ca, input logic [2:0] cp,
                        input logic hr, input logic [16:0] ha, input logic [2:0] hp);
        logic eg_c, ev_c, eg_h, ev_h;
        logic [16:0] ea;
        kw_en = we; kw_blk = wb; kw_key = wk;
        cpu_req = cr; cpu_addr = ca; cpu_pnum = cp;
        chn_req = hr; chn_addr = ha; chn_pnum = hp;
        // Expected results from keys before this cycle's write (R9)
        eg_c = cr && key_ok(ca, cp);
        ev_c = cr && !key_ok(ca, cp);
        eg_h = hr && key_ok(ha, hp);
        ev_h = hr && !key_ok(ha, hp);
        ea   = ev_c ? ca : (ev_h ? ha : 17'h0);
        if (we) mdl[wb] = wk;
        @(negedge clk);
        chk("R3 cpu_grant", {16'h0, cpu_grant}, {16'h0, eg_c});
        chk("R3 cpu_viol",  {16'h0, cpu_viol},  {16'h0, ev_c});
        chk("R4 chn_grant", {16'h0, chn_grant}, {16'h0, eg_h});
        chk("R4 chn_viol",  {16'h0, chn_viol},  {16'h0, ev_h});
        chk("R7 err_irq",   {16'h0, err_irq},   {16'h0, ev_c || ev_h});
        chk("R7 err_src",   {16'h0, err_src},   {16'h0, !ev_c && ev_h});
        chk("R7 err_addr",  err_addr, ea);
        chk("R8 err_dual",  {16'h0, err_dual},  {16'h0, ev_c && ev_h});
    endtask

    task automatic idle();
        step(1'b0, 6'd0, 3'd0, 1'b0, 17'h0, 3'd0, 1'b0, 17'h0, 3'd0);
    endtask

    initial begin
        #1_600_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1977));
        for (int i = 0; i < 64; i++) mdl[i] = 3'd0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1 reset grant", {15'h0, cpu_grant, chn_grant}, 17'h0);
        chk("R1 reset viol",  {15'h0, cpu_viol, chn_viol}, 17'h0);
        chk("R1 reset irq",   {14'h0, err_irq, err_src, err_dual}, 17'h0);
        chk("R1 reset addr",  err_addr, 17'h0);
        rst_n = 1'b1;
        // R1: all keys zero -> program 0 granted everywhere, program 5 rejected
        for (int b = 0; b < 64; b++)
            step(1'b0, 6'd0, 3'd0, 1'b1, {b[5:0], 11'h155}, 3'd0,
                 1'b1, {b[5:0], 11'h2AA}, 3'd5);
        // R2, R10: boundary blocks
        step(1'b1, 6'd0, 3'd2, 1'b0, 17'h0, 3'd0, 1'b0, 17'h0, 3'd0);
        step(1'b1, 6'd1, 3'd6, 1'b0, 17'h0, 3'd0, 1'b0, 17'h0, 3'd0);
        step(1'b1, 6'd63, 3'd7, 1'b0, 17'h0, 3'd0, 1'b0, 17'h0, 3'd0);
        step(1'b0, 6'd0, 3'd0, 1'b1, 17'h007FF, 3'd2, 1'b1, 17'h00800, 3'd6);
        step(1'b0, 6'd0, 3'd0, 1'b1, 17'h00800, 3'd2, 1'b1, 17'h007FF, 3'd6);
        step(1'b0, 6'd0, 3'd0, 1'b1, 17'h1FFFF, 3'd7, 1'b1, 17'h1F800, 3'd0);
        // R9: write and check the same block in one cycle
        step(1'b1, 6'd5, 3'd4, 1'b1, 17'h02C10, 3'd4, 1'b1, 17'h02800, 3'd0);
        step(1'b0, 6'd0, 3'd0, 1'b1, 17'h02C10, 3'd4, 1'b1, 17'h02800, 3'd0);
        // R8: both violate; R7: processor address reported
        step(1'b0, 6'd0, 3'd0, 1'b1, 17'h00123, 3'd1, 1'b1, 17'h00ABC, 3'd3);
        // R7: only channel violates
        step(1'b0, 6'd0, 3'd0, 1'b1, 17'h00123, 3'd2, 1'b1, 17'h1FFF0, 3'd1);
        // R6: idle cycle after violations clears pulses
        idle();
        idle();
        // Random traffic on a narrow key range
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 3) == 0, 6'($urandom), 3'($urandom_range(0, 2)),
                 $urandom_range(0, 3) != 0, 17'($urandom), 3'($urandom_range(0, 2)),
                 $urandom_range(0, 3) != 0, 17'($urandom), 3'($urandom_range(0, 2)));
        end
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule